// File: doc/BRIEF.md
# NAND Hamming ECC Syndrome Corrector

This block checks one chunk of NAND flash data after a read. It takes the 24-bit check code that was stored in the spare area and the 24-bit code that was recomputed over the chunk. It XORs the two codes byte by byte to get a syndrome. It then decides whether the chunk is clean, has one data bit to flip, has a fault only in the stored code, or cannot be repaired. For a repairable chunk it reports the byte offset inside the chunk and the bit to flip. Whatever holds the data buffer applies the flip. Computing the code and editing the buffer are not part of this block.

The chunk size is set at build time from the page size. Pages of 1 KiB or less use 512-byte chunks, and larger pages use 256-byte chunks. The code is three bytes long in both cases. The code inputs, the blank-code enable and the start strobe are plain control pins with no handshake. A result is produced for every start pulse, and the block never back-pressures the caller.

Top module: `ecc_syn_fix`

## Requirements
- R1: After reset, `done_o` is 0, `status_o` is 0 (clean) and both index outputs are 0.
- R2: A syndrome of all zeros (stored code equal to computed code) gives status 0 (clean) with both indices 0.
- R3: A syndrome is correctable only when each of its three bytes has exactly one bit set in every aligned bit pair (1:0, 3:2, 5:4, 7:6). The bit index is then syndrome bits 19, 21 and 23, taken as index bits 0, 1 and 2. The status is 1 (corrected).
- R4: For a correctable syndrome, byte index bits 3:0 are syndrome bits 7, 5, 3, 1. Byte index bits 7:4 are syndrome bits 15, 13, 11, 9. Byte index bit 8 is syndrome bit 17. In each case, bit 0 of the 24-bit vector is bit 0 of the low code byte.
- R5: A syndrome with exactly one bit set gives status 2 (fault in the stored code). Both indices are 0, so no data bit is flipped.
- R6: Any other non-zero syndrome gives status 3 (uncorrectable) with both indices 0. This includes a syndrome that has a single broken pair.
- R7: The chunk is 512 bytes when PAGE_BYTES ≤ 1024 and 256 bytes otherwise. A correctable syndrome whose byte index is at or beyond the chunk size gives status 3 with both indices 0.
- R8: `done_o` pulses for one cycle in the clock cycle after `start_i`, together with the new result. The result outputs hold their values until the next start, whatever the inputs do in between.
- R9: When the stored code is FF FF FF and `ignore_blank_i` is 1, the status is 0 (clean) even for a non-zero syndrome. When `ignore_blank_i` is 0, the same codes are classified as in R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe: evaluate the current codes |
| ecc_stored_i | input | 24 | Code read from the spare area, bits 7:0 = first byte |
| ecc_calc_i | input | 24 | Code computed over the chunk, same byte order |
| ignore_blank_i | input | 1 | Treat an all-ones stored code as an unwritten page |
| done_o | output | 1 | One-cycle pulse when a new result is presented |
| status_o | output | 2 | 0 clean, 1 corrected, 2 stored-code fault, 3 uncorrectable |
| byte_idx_o | output | 9 | Byte offset to repair (0 unless corrected) |
| bit_idx_o | output | 3 | Bit within that byte to flip (0 unless corrected) |

## Verification
The bench builds two copies of the block. One uses PAGE_BYTES = 512, which gives 512-byte chunks, so every 9-bit byte index is in range. The other uses the default of 2048, which gives 256-byte chunks. Feeding both the same syndromes makes the range limit show up: indices 256 to 511 are repaired by the first copy and rejected by the second, and index 255 is accepted by both. Syndromes are built from a chosen byte and bit, so the position mapping is checked in the forward direction against the decoder.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int CODE_W = 24;
  localparam int BYTE_W = 9;
  localparam int BIT_W  = 3;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXED    = 2'd1,
    ST_CODE_ERR = 2'd2,
    ST_FATAL    = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc_syn_map.sv
// Turns a syndrome into its pair-check flags and location fields.
module ecc_syn_map
  import ecc_fix_pkg::*;
(
  input  logic [CODE_W-1:0] syn_i,
  output logic              pairs_ok_o,
  output logic              single_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [BIT_W-1:0]  bit_o
);
  localparam int NBYTES = CODE_W / 8;

  logic [NBYTES-1:0] byte_ok;

  // Each syndrome byte must hold 01 or 10 in all four aligned pairs.
  for (genvar g = 0; g < NBYTES; g++) begin : g_pair
    logic [7:0] d;
    assign d          = syn_i[8*g +: 8];
    assign byte_ok[g] = (((d ^ (d >> 1)) & 8'h55) == 8'h55);
  end

  // The odd bits of the two low bytes give byte index bits 7:0.
  for (genvar i = 0; i < 4; i++) begin : g_addr
    assign byte_o[i]     = syn_i[2*i + 1];
    assign byte_o[4 + i] = syn_i[8 + 2*i + 1];
  end
  assign byte_o[8] = syn_i[17];
  assign bit_o     = {syn_i[23], syn_i[21], syn_i[19]};

  assign pairs_ok_o = &byte_ok;
  assign single_o   = (syn_i != '0) && ((syn_i & (syn_i - 1'b1)) == '0);
endmodule

// File: rtl/ecc_classify.sv
// Chooses the verdict from the syndrome flags and the chunk limit.
module ecc_classify
  import ecc_fix_pkg::*;
#(
  parameter int CHUNK_BYTES = 256
) (
  input  logic [CODE_W-1:0] stored_i,
  input  logic [CODE_W-1:0] syn_i,
  input  logic              ignore_blank_i,
  input  logic              pairs_ok_i,
  input  logic              single_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BIT_W-1:0]  bit_i,
  output ecc_status_e       status_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [BIT_W-1:0]  bit_o
);
  localparam logic [BYTE_W:0] LIMIT = (BYTE_W+1)'(CHUNK_BYTES);

  logic blank;
  logic in_chunk;

  assign blank    = ignore_blank_i && (stored_i == {CODE_W{1'b1}});
  assign in_chunk = ({1'b0, byte_i} < LIMIT);

  always_comb begin
    status_o = ST_CLEAN;
    byte_o   = '0;
    bit_o    = '0;
    if (syn_i == '0 || blank) begin
      status_o = ST_CLEAN;
    end else if (pairs_ok_i) begin
      if (in_chunk) begin
        status_o = ST_FIXED;
        byte_o   = byte_i;
        bit_o    = bit_i;
      end else begin
        status_o = ST_FATAL;
      end
    end else if (single_i) begin
      status_o = ST_CODE_ERR;
    end else begin
      status_o = ST_FATAL;
    end
  end
endmodule

// File: rtl/ecc_syn_fix.sv
module ecc_syn_fix
  import ecc_fix_pkg::*;
#(
  parameter int PAGE_BYTES  = 2048,
  parameter int PAGE_SPLIT  = 1024,
  parameter int SMALL_CHUNK = 512,
  parameter int LARGE_CHUNK = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [23:0] ecc_stored_i,
  input  logic [23:0] ecc_calc_i,
  input  logic        ignore_blank_i,
  output logic        done_o,
  output logic [1:0]  status_o,
  output logic [8:0]  byte_idx_o,
  output logic [2:0]  bit_idx_o
);
  localparam int CHUNK = (PAGE_BYTES > PAGE_SPLIT) ? LARGE_CHUNK : SMALL_CHUNK;

  logic [CODE_W-1:0] syn;
  logic              pairs_ok;
  logic              single;
  logic [BYTE_W-1:0] map_byte, nxt_byte;
  logic [BIT_W-1:0]  map_bit, nxt_bit;
  ecc_status_e       nxt_status;

  assign syn = ecc_stored_i ^ ecc_calc_i;

  ecc_syn_map u_map (
    .syn_i      (syn),
    .pairs_ok_o (pairs_ok),
    .single_o   (single),
    .byte_o     (map_byte),
    .bit_o      (map_bit)
  );

  ecc_classify #(.CHUNK_BYTES(CHUNK)) u_cls (
    .stored_i       (ecc_stored_i),
    .syn_i          (syn),
    .ignore_blank_i (ignore_blank_i),
    .pairs_ok_i     (pairs_ok),
    .single_i       (single),
    .byte_i         (map_byte),
    .bit_i          (map_bit),
    .status_o       (nxt_status),
    .byte_o         (nxt_byte),
    .bit_o          (nxt_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      status_o   <= ST_CLEAN;
      byte_idx_o <= '0;
      bit_idx_o  <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        status_o   <= nxt_status;
        byte_idx_o <= nxt_byte;
        bit_idx_o  <= nxt_bit;
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable({status_o, byte_idx_o, bit_idx_o}));
  // R7
  in_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_FIXED) |-> ({1'b0, byte_idx_o} < 10'(CHUNK)));
  // R5
  no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != ST_FIXED) |-> (byte_idx_o == '0 && bit_idx_o == '0));
  // R3
  pair_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pairs_ok |-> ($countones(syn) == 12));
endmodule

// File: tb/test_ecc_syn_fix.sv
module test_ecc_syn_fix;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored = '0;
  logic [23:0] calc = '0;
  logic        ign = 1'b0;

  logic       done_a, done_b;
  logic [1:0] st_a, st_b;
  logic [8:0] by_a, by_b;
  logic [2:0] bi_a, bi_b;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [23:0] BASE = 24'h5C3A91;

  always #5 clk = ~clk;

  // 512-byte chunk
  ecc_syn_fix #(.PAGE_BYTES(512)) i_ecc_syn_fix (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ecc_stored_i(stored),
    .ecc_calc_i(calc), .ignore_blank_i(ign), .done_o(done_a),
    .status_o(st_a), .byte_idx_o(by_a), .bit_idx_o(bi_a));

  // 256-byte chunk (default page size)
  ecc_syn_fix i_ecc_syn_fix_lg (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ecc_stored_i(stored),
    .ecc_calc_i(calc), .ignore_blank_i(ign), .done_o(done_b),
    .status_o(st_b), .byte_idx_o(by_b), .bit_idx_o(bi_b));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Syndrome that points at a chosen byte and bit
  function automatic logic [23:0] enc(input int unsigned b, input int unsigned k);
    logic [23:0] s;
    logic [8:0]  bb;
    logic [2:0]  kk;
    bb = 9'(b);
    kk = 3'(k);
    s = '0;
    for (int i = 0; i < 4; i++) begin
      s[2*i+1]   = bb[i];     s[2*i]   = ~bb[i];
      s[8+2*i+1] = bb[4+i];   s[8+2*i] = ~bb[4+i];
    end
    s[17] = bb[8]; s[16] = ~bb[8];
    s[19] = kk[0]; s[18] = ~kk[0];
    s[21] = kk[1]; s[20] = ~kk[1];
    s[23] = kk[2]; s[22] = ~kk[2];
    return s;
  endfunction

  task automatic run(input logic [23:0] st_code, input logic [23:0] cl_code, input bit ig,
                     input int es, input int eb, input int ek, input string tag);
    int es_b, eb_b, ek_b;
    es_b = es; eb_b = eb; ek_b = ek;
    if (es == 1 && eb >= 256) begin es_b = 3; eb_b = 0; ek_b = 0; end
    @(negedge clk);
    stored = st_code; calc = cl_code; ign = ig; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done_a === 1'b1 && done_b === 1'b1, {tag, " R8 done"}, {done_a, done_b}, 3);
    check(st_a === 2'(es), {tag, " status A"}, st_a, es);
    check(by_a === 9'(eb) && bi_a === 3'(ek), {tag, " index A"}, {by_a, bi_a}, (eb << 3) | ek);
    check(st_b === 2'(es_b), {tag, " R7 status B"}, st_b, es_b);
    check(by_b === 9'(eb_b) && bi_b === 3'(ek_b), {tag, " R7 index B"},
          {by_b, bi_b}, (eb_b << 3) | ek_b);
    @(negedge clk);
    check(done_a === 1'b0 && done_b === 1'b0, {tag, " R8 pulse"}, {done_a, done_b}, 0);
  endtask

  task automatic t_reset();
    check(done_a === 1'b0 && st_a === 2'd0 && by_a === 9'd0 && bi_a === 3'd0,
          "R1 reset A", {done_a, st_a, by_a, bi_a}, 0);
    check(done_b === 1'b0 && st_b === 2'd0, "R1 reset B", {done_b, st_b}, 0);
  endtask

  task automatic t_clean();
    run(BASE, BASE, 1'b0, 0, 0, 0, "R2 equal");
    run(24'hFFFFFF, 24'hFFFFFF, 1'b1, 0, 0, 0, "R2 equal blank");
  endtask

  task automatic t_fix();
    run(BASE ^ enc(0, 0), BASE, 1'b0, 1, 0, 0, "R3 R4 b0k0");
    run(BASE ^ enc(9'h1A5, 5), BASE, 1'b0, 1, 9'h1A5, 5, "R3 R4 b1a5k5");
    run(BASE ^ enc(255, 7), BASE, 1'b0, 1, 255, 7, "R7 b255 edge");
    run(BASE ^ enc(256, 3), BASE, 1'b0, 1, 256, 3, "R7 b256 edge");
    run(BASE ^ enc(511, 2), BASE, 1'b0, 1, 511, 2, "R4 b511k2");
    run(BASE ^ enc(9'h05A, 6), BASE, 1'b0, 1, 9'h05A, 6, "R4 b05ak6");
  endtask

  task automatic t_code_err();
    run(BASE ^ 24'h000001, BASE, 1'b0, 2, 0, 0, "R5 bit0");
    run(BASE ^ 24'h000800, BASE, 1'b0, 2, 0, 0, "R5 bit11");
    run(BASE ^ 24'h800000, BASE, 1'b0, 2, 0, 0, "R5 bit23");
  endtask

  task automatic t_fatal();
    run(BASE ^ 24'h000003, BASE, 1'b0, 3, 0, 0, "R6 two bits");
    run(BASE ^ enc(77, 1) ^ 24'h000100, BASE, 1'b0, 3, 0, 0, "R6 broken pair");
  endtask

  task automatic t_blank();
    run(24'hFFFFFF, 24'h00A5C3, 1'b1, 0, 0, 0, "R9 blank ignored");
    run(24'hFFFFFF, 24'h00A5C3, 1'b0, 3, 0, 0, "R9 blank not ignored");
    run(24'hFFFFFF, 24'hFFFFFF ^ enc(3, 1), 1'b0, 1, 3, 1, "R9 blank fix");
  endtask

  task automatic t_hold();
    run(BASE ^ enc(200, 4), BASE, 1'b0, 1, 200, 4, "R8 hold setup");
    @(negedge clk);
    stored = 24'h000003; calc = 24'h0; ign = 1'b1;
    repeat (3) @(negedge clk);
    check(st_a === 2'd1 && by_a === 9'd200 && bi_a === 3'd4, "R8 hold A",
          {st_a, by_a, bi_a}, {2'd1, 9'd200, 3'd4});
    check(st_b === 2'd1 && by_b === 9'd200 && done_b === 1'b0, "R8 hold B",
          {st_b, by_b, done_b}, {2'd1, 9'd200, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_fix();
    t_code_err();
    t_fatal();
    t_blank();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule